// File: doc/BRIEF.md
# Synchronous Serial Master with Register Interface

This block is a serial master that sits on a 32-bit register bus. Software sets the clock polarity, the clock phase, the bit order and a frame length of 4 to 16 bits. It sets the serial clock rate through a divider. It then writes words into a small transmit buffer. A shift engine sends each word out on MOSI and captures MISO at the same time. Each captured word goes into a small receive buffer, which software drains by reading. Chip select is driven outside the block.

Separate commands switch the receiver, the transmitter and master operation on and off. Each command bit is a write-one pulse. Level conditions and a sticky overflow event form an interrupt flag word. Software can also set or clear the flags, and it has an enable mask. The block drives two interrupt lines, one for receive and one for transmit. A pin-routing register is only stored and read back.

Top module: `ssm_top`

## Requirements
- R1: After reset, the status register (0x10) reads 0x40. The flag register (0x40) reads 0x02. Both interrupt lines and SCLK are low.
- R2: Writing the command register (0x0C) acts on each bit set to 1. Bit 0 turns the receiver on and bit 1 turns it off. Bit 2 turns the transmitter on and bit 3 turns it off. Bit 4 turns master operation on and bit 5 turns it off. When both the on bit and the off bit of a function are set, off wins. Status bits 0, 1 and 2 show the receiver, transmitter and master states. The command register reads 0.
- R3: The frame register (0x04) bits [3:0] hold the frame length minus 3 and read back as written. A code of 0 gives 4-bit frames. Codes above 13 give 16-bit frames.
- R4: Control (0x00) bit 8 sets the idle level of SCLK. Control bit 9 selects the sampling edge. When it is 0, MISO is sampled on the leading edge and MOSI changes on the trailing edge. When it is 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge. Each SCLK half period lasts (divider register 0x14 + 1) clock cycles.
- R5: Control bit 10 set sends and receives the most significant bit first. When it is clear, the least significant bit goes first.
- R6: Writing 0x34 pushes a word into a 2-entry transmit buffer. A write to a full buffer is dropped.
- R7: Frames are shifted only while control bit 0, master mode and the transmitter are all on and the transmit buffer holds a word. Otherwise SCLK makes no edges.
- R8: Received words enter a 2-entry buffer while the receiver is on. Status bit 7 is set while this buffer is not empty. Reading 0x1C returns the whole word and pops it. Reading 0x18 returns the word's bits [8:0] with zero error flags in bits 14 and 15, and also pops it. A frame that ends while the receiver is off is discarded. A frame that ends while the buffer is full is dropped and sets flag bit 5.
- R9: Status bit 6 depends on control bit 12. When bit 12 is 1, status bit 6 is set while at least one transmit slot is free. When bit 12 is 0, it is set only while the transmit buffer is empty.
- R10: Status bit 5 is set when a frame ends with the transmit buffer empty. It clears on a write to 0x34.
- R11: Flag bit 1 is the status bit 6 condition OR a software-set bit. Flag bit 2 is the status bit 7 condition OR a software-set bit. Writing 0x44 sets flag bits and writing 0x48 clears them. Neither write can remove a live level condition. Flag bit 5 is sticky until cleared through 0x48.
- R12: The receive line is (flag AND enable) bit 2, and the transmit line is (flag AND enable) bit 1. The enable mask is register 0x4C. Both lines are registered one cycle after their inputs.
- R13: The route register (0x54) stores bits 0, 1, 3 and [10:8] and reads back 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The bench uses the default parameters: 16-bit data, 2-entry buffers and an 8-bit divider. Two entries are enough to reach the full-buffer cases of both buffers: a dropped transmit write and a dropped receive frame with its sticky overflow flag. The divider is kept to 0 to 2, so each frame takes at most about a hundred cycles. This leaves room for many random frames that vary polarity, phase, bit order and every length from 4 to 16. A serial slave model in the bench records each edge. It checks the half-period length against the divider.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_FRAME = 'h04;
  localparam int OFS_CMD   = 'h0C;
  localparam int OFS_STAT  = 'h10;
  localparam int OFS_DIV   = 'h14;
  localparam int OFS_RXX   = 'h18;
  localparam int OFS_RXD   = 'h1C;
  localparam int OFS_TXD   = 'h34;
  localparam int OFS_IF    = 'h40;
  localparam int OFS_IFS   = 'h44;
  localparam int OFS_IFC   = 'h48;
  localparam int OFS_IEN   = 'h4C;
  localparam int OFS_ROUTE = 'h54;

  typedef struct packed {
    logic sync;
    logic cpol;
    logic cpha;
    logic msbf;
    logic lvl;
  } mode_t;
endpackage

// File: rtl/ssm_fifo.sv
module ssm_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       empty,
  output logic                       full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_pop, do_push;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R6
  fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R6
  fifo_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && full) |=> $stable(count));
endmodule

// File: rtl/ssm_shifter.sv
module ssm_shifter #(
  parameter int DW   = 16,
  parameter int DIVW = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     run,
  input  logic                     cpol,
  input  logic                     cpha,
  input  logic                     msbf,
  input  logic [$clog2(DW+1)-1:0]  nbits,
  input  logic [DIVW-1:0]          div,
  input  logic                     tx_valid,
  input  logic [DW-1:0]            tx_word,
  input  logic                     miso,
  output logic                     tx_take,
  output logic                     rx_done,
  output logic [DW-1:0]            rx_word,
  output logic                     busy,
  output logic                     sclk,
  output logic                     mosi
);
  localparam int NBW = $clog2(DW+1);

  logic [DW-1:0]   word, rsr, rsr_n;
  logic [NBW:0]    hc;
  logic [DIVW-1:0] dcnt, lat_div;
  logic [NBW-1:0]  lat_nb;
  logic            lat_cpha, lat_msbf;
  logic            tick, samp, last;
  int              b, nb;

  function automatic int pos(input logic first_msb, input int n, input int i);
    return first_msb ? (n - 1 - i) : i;
  endfunction

  assign tx_take = !busy && run && tx_valid;

  always_comb begin
    nb    = int'(lat_nb);
    b     = int'(hc[NBW:1]);
    tick  = busy && (dcnt == lat_div);
    samp  = tick && (lat_cpha ? hc[0] : !hc[0]);
    last  = tick && (int'(hc) == 2*nb - 1);
    rsr_n = rsr;
    if (samp) rsr_n[pos(lat_msbf, nb, b)] = miso;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      sclk     <= 1'b0;
      mosi     <= 1'b0;
      hc       <= '0;
      dcnt     <= '0;
      word     <= '0;
      rsr      <= '0;
      rx_word  <= '0;
      rx_done  <= 1'b0;
      lat_nb   <= '0;
      lat_div  <= '0;
      lat_cpha <= 1'b0;
      lat_msbf <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (!busy) begin
        sclk <= cpol;
        if (tx_take) begin
          busy     <= 1'b1;
          word     <= tx_word;
          lat_nb   <= nbits;
          lat_div  <= div;
          lat_cpha <= cpha;
          lat_msbf <= msbf;
          hc       <= '0;
          dcnt     <= '0;
          rsr      <= '0;
          if (!cpha) mosi <= tx_word[pos(msbf, int'(nbits), 0)];
        end
      end else begin
        rsr <= rsr_n;
        if (tick) begin
          dcnt <= '0;
          sclk <= ~sclk;
          hc   <= hc + 1'b1;
          if (!hc[0]) begin
            if (lat_cpha) mosi <= word[pos(lat_msbf, nb, b)];
          end else if (!lat_cpha && (b < nb - 1)) begin
            mosi <= word[pos(lat_msbf, nb, b + 1)];
          end
          if (last) begin
            busy    <= 1'b0;
            rx_done <= 1'b1;
            rx_word <= rsr_n;
          end
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end
    end
  end

  // R7
  no_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !run) |=> !busy);

  // R7
  take_start_chk: assert property (@(posedge clk) disable iff (rst)
    tx_take |=> busy);

  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sclk == cpol));
endmodule

// File: rtl/ssm_top.sv
module ssm_top
  import ssm_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 2,
  parameter int DIVW  = 8,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic          rx_irq,
  output logic          tx_irq
);
  localparam int NBW = $clog2(DW+1);
  localparam int CW  = $clog2(DEPTH+1);

  mode_t           mode;
  logic [3:0]      fcode;
  logic            rx_on, tx_on, ms_on;
  logic [DIVW-1:0] div_q;
  logic [2:1]      swf;
  logic            ovf, txc;
  logic [2:0]      ien_q;
  logic [2:0]      route_en;
  logic [2:0]      route_loc;
  logic [NBW-1:0]  nbits;

  logic [DW-1:0]   tx_dout, rx_dout, sh_rx;
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic            tx_empty, tx_full, rx_empty, rx_full;
  logic            sh_take, sh_done, sh_busy;
  logic            w_ctrl, w_frame, w_cmd, w_div, w_txd, w_ifs, w_ifc, w_ien, w_route;
  logic            rx_pop, rx_push, rx_lost;
  logic            txbl_c, rxv_c;
  logic [31:0]     if_v, stat_v;

  function automatic logic hit(input logic [AW-1:0] a, input int ofs);
    return a == AW'(ofs);
  endfunction

  assign w_ctrl  = bus_wr && hit(bus_addr, OFS_CTRL);
  assign w_frame = bus_wr && hit(bus_addr, OFS_FRAME);
  assign w_cmd   = bus_wr && hit(bus_addr, OFS_CMD);
  assign w_div   = bus_wr && hit(bus_addr, OFS_DIV);
  assign w_txd   = bus_wr && hit(bus_addr, OFS_TXD);
  assign w_ifs   = bus_wr && hit(bus_addr, OFS_IFS);
  assign w_ifc   = bus_wr && hit(bus_addr, OFS_IFC);
  assign w_ien   = bus_wr && hit(bus_addr, OFS_IEN);
  assign w_route = bus_wr && hit(bus_addr, OFS_ROUTE);

  // frame length decode with clamping
  always_comb begin
    if (fcode == 4'd0)            nbits = NBW'(4);
    else if (int'(fcode) + 3 > DW) nbits = NBW'(DW);
    else                          nbits = NBW'(int'(fcode) + 3);
  end

  assign rx_pop  = bus_rd && (hit(bus_addr, OFS_RXX) || hit(bus_addr, OFS_RXD)) && !rx_empty;
  assign rx_push = sh_done && rx_on;
  assign rx_lost = rx_push && rx_full && !rx_pop;

  ssm_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(w_txd), .pop(sh_take),
    .din(bus_wdata[DW-1:0]), .dout(tx_dout), .count(tx_cnt),
    .empty(tx_empty), .full(tx_full)
  );

  ssm_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .pop(rx_pop),
    .din(sh_rx), .dout(rx_dout), .count(rx_cnt),
    .empty(rx_empty), .full(rx_full)
  );

  ssm_shifter #(.DW(DW), .DIVW(DIVW)) u_shift (
    .clk(clk), .rst(rst), .run(mode.sync && ms_on && tx_on),
    .cpol(mode.cpol), .cpha(mode.cpha), .msbf(mode.msbf),
    .nbits(nbits), .div(div_q), .tx_valid(!tx_empty), .tx_word(tx_dout),
    .miso(miso), .tx_take(sh_take), .rx_done(sh_done), .rx_word(sh_rx),
    .busy(sh_busy), .sclk(sclk), .mosi(mosi)
  );

  assign txbl_c = mode.lvl ? !tx_full : tx_empty;
  assign rxv_c  = !rx_empty;

  always_comb begin
    if_v    = '0;
    if_v[1] = txbl_c | swf[1];
    if_v[2] = rxv_c  | swf[2];
    if_v[5] = ovf;
    stat_v    = '0;
    stat_v[0] = rx_on;
    stat_v[1] = tx_on;
    stat_v[2] = ms_on;
    stat_v[5] = txc;
    stat_v[6] = txbl_c;
    stat_v[7] = rxv_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= '0;
      fcode     <= '0;
      rx_on     <= 1'b0;
      tx_on     <= 1'b0;
      ms_on     <= 1'b0;
      div_q     <= '0;
      swf       <= '0;
      ovf       <= 1'b0;
      txc       <= 1'b0;
      ien_q     <= '0;
      route_en  <= '0;
      route_loc <= '0;
    end else begin
      if (w_ctrl) begin
        mode.sync <= bus_wdata[0];
        mode.cpol <= bus_wdata[8];
        mode.cpha <= bus_wdata[9];
        mode.msbf <= bus_wdata[10];
        mode.lvl  <= bus_wdata[12];
      end
      if (w_frame) fcode <= bus_wdata[3:0];
      if (w_cmd) begin
        rx_on <= (rx_on | bus_wdata[0]) & ~bus_wdata[1];
        tx_on <= (tx_on | bus_wdata[2]) & ~bus_wdata[3];
        ms_on <= (ms_on | bus_wdata[4]) & ~bus_wdata[5];
      end
      if (w_div) div_q <= bus_wdata[DIVW-1:0];
      if (w_ifs) begin
        swf <= swf | bus_wdata[2:1];
        if (bus_wdata[5]) ovf <= 1'b1;
      end
      if (w_ifc) begin
        swf <= swf & ~bus_wdata[2:1];
        if (bus_wdata[5]) ovf <= 1'b0;
      end
      if (rx_lost) ovf <= 1'b1;
      if (w_ien) ien_q <= {bus_wdata[5], bus_wdata[2], bus_wdata[1]};
      if (w_route) begin
        route_en  <= {bus_wdata[3], bus_wdata[1], bus_wdata[0]};
        route_loc <= bus_wdata[10:8];
      end
      if (sh_done && tx_empty) txc <= 1'b1;
      if (w_txd) txc <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_irq <= 1'b0;
      tx_irq <= 1'b0;
    end else begin
      rx_irq <= if_v[2] & ien_q[1];
      tx_irq <= if_v[1] & ien_q[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      if (hit(bus_addr, OFS_CTRL))
        bus_rdata <= {19'b0, mode.lvl, 1'b0, mode.msbf, mode.cpha, mode.cpol, 7'b0, mode.sync};
      else if (hit(bus_addr, OFS_FRAME)) bus_rdata <= {28'b0, fcode};
      else if (hit(bus_addr, OFS_STAT))  bus_rdata <= stat_v;
      else if (hit(bus_addr, OFS_DIV))   bus_rdata <= 32'(div_q);
      else if (hit(bus_addr, OFS_RXX))   bus_rdata <= 32'(rx_dout) & 32'h0000_01FF;
      else if (hit(bus_addr, OFS_RXD))   bus_rdata <= 32'(rx_dout);
      else if (hit(bus_addr, OFS_IF))    bus_rdata <= if_v;
      else if (hit(bus_addr, OFS_IEN))
        bus_rdata <= {26'b0, ien_q[2], 2'b0, ien_q[1], ien_q[0], 1'b0};
      else if (hit(bus_addr, OFS_ROUTE))
        bus_rdata <= {21'b0, route_loc, 4'b0, route_en[2], 1'b0, route_en[1], route_en[0]};
    end
  end

  // R2
  rxdis_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (w_cmd && bus_wdata[1]) |=> !rx_on);

  // R8
  rx_drop_chk: assert property (@(posedge clk) disable iff (rst)
    rx_lost |=> (ovf && $stable(rx_cnt)));

  // R12
  txirq_src_chk: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> $past(ien_q[0]));

  // R8
  rx_off_chk: assert property (@(posedge clk) disable iff (rst)
    (sh_done && !rx_on && !rx_pop) |=> $stable(rx_cnt));
endmodule

// File: tb/tb_ssm_top.sv
`timescale 1ns/1ps
module tb_ssm_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        sclk, mosi, rx_irq, tx_irq;
  logic        miso = 1'b0;

  ssm_top dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // serial slave model
  logic        m_cpol = 0, m_cpha = 0, m_msbf = 0;
  int          m_nb = 8, iv_exp = 1;
  logic [15:0] sw = '0, cap = '0;
  logic [15:0] capq [8];
  int          lead_n = 0, trail_n = 0, cap_n = 0, edges = 0, iv_bad = 0, last_cyc = 0;
  int          clr_req = 0, clr_seen = 0;
  bit          have_last = 0;
  logic        prev_sclk = 0;

  always @(negedge clk) begin
    if (clr_req != clr_seen) begin
      clr_seen = clr_req;
      lead_n = 0; trail_n = 0; cap = '0; cap_n = 0; edges = 0; iv_bad = 0;
      have_last = 0; prev_sclk = sclk;
      miso <= sw[m_msbf ? m_nb-1 : 0];
    end else if (sclk !== prev_sclk) begin
      logic lead;
      int   k, k2;
      prev_sclk = sclk;
      edges++;
      if (have_last && (cyc - last_cyc) != iv_exp) iv_bad++;
      last_cyc = cyc;
      have_last = 1;
      lead = (sclk != m_cpol);
      if (lead != m_cpha) begin
        k = (m_cpha ? trail_n : lead_n) % m_nb;
        cap[m_msbf ? m_nb-1-k : k] = mosi;
        if (k == m_nb-1) begin
          capq[cap_n % 8] = cap;
          cap_n++;
          cap = '0;
        end
      end
      if (lead) lead_n++;
      else begin
        trail_n++;
        if (trail_n % m_nb == 0) have_last = 0;
      end
      k2 = m_cpha ? (lead_n + m_nb - 1) % m_nb : trail_n % m_nb;
      miso <= sw[m_msbf ? m_nb-1-k2 : k2];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic cfg(input logic cp, input logic ph, input logic mf, input int nb, input int dv);
    wr(8'h00, 32'h1001 | (32'(cp) << 8) | (32'(ph) << 9) | (32'(mf) << 10));
    wr(8'h04, 32'(nb - 3));
    wr(8'h14, 32'(dv));
    m_cpol = cp; m_cpha = ph; m_msbf = mf; m_nb = nb; iv_exp = dv + 1;
    repeat (2) @(negedge clk);
    clr_req++;
    @(negedge clk);
  endtask

  task automatic wait_txc();
    logic [31:0] s;
    for (int i = 0; i < 600; i++) begin
      rd(8'h10, s);
      if (s[5]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] msk(input int nb);
    return (32'd1 << nb) - 1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 sclk", 32'(sclk), 0);
    chk("R1 irqs", {30'b0, rx_irq, tx_irq}, 0);
    rd(8'h10, d); chk("R1 status", d, 32'h40);
    rd(8'h40, d); chk("R1 flags", d, 32'h02);

    // R13 route
    wr(8'h54, 32'hFFFF_FFFF);
    rd(8'h54, d); chk("R13 route", d, 32'h0000_070B);

    // R2 commands
    wr(8'h0C, 32'h15);
    rd(8'h10, d); chk("R2 enable", d, 32'h47);
    wr(8'h0C, 32'h03);
    rd(8'h10, d); chk("R2 off wins", d, 32'h46);
    wr(8'h0C, 32'h01);
    rd(8'h0C, d); chk("R2 cmd reads 0", d, 0);
    rd(8'h10, d); chk("R2 rx back on", d, 32'h47);

    // R7 and R9: sync off holds the word
    cfg(0, 0, 1, 8, 0);
    wr(8'h00, 32'h1400);
    wr(8'h34, 32'h5A);
    repeat (100) @(negedge clk);
    chk("R7 no edges", 32'(edges), 0);
    rd(8'h10, d); chk("R9 lvl1 slot free", 32'(d[6]), 1);
    wr(8'h00, 32'h0400);
    rd(8'h10, d); chk("R9 lvl0 not empty", 32'(d[6]), 0);
    sw = 16'h00C3;
    clr_req++; @(negedge clk);
    wr(8'h00, 32'h1401);
    wait_txc();
    chk("R7 frame sent", 32'(capq[0]), 32'h5A);
    rd(8'h1C, d); chk("R8 rx word", d, 32'hC3);
    rd(8'h10, d); chk("R10 txc set", 32'(d[5]), 1);

    // R3 clamping
    sw = 16'hBEEF;
    cfg(0, 1, 0, 4, 1);
    wr(8'h04, 32'h0);
    rd(8'h04, d); chk("R3 readback", d, 0);
    wr(8'h34, 32'hFFF6);
    wait_txc();
    chk("R3 4-bit tx", 32'(capq[0]), 32'h6);
    rd(8'h1C, d); chk("R3 4-bit rx", d, 32'hF);
    cfg(1, 0, 1, 16, 0);
    wr(8'h04, 32'hF);
    wr(8'h34, 32'hA5C3);
    wait_txc();
    chk("R3 16-bit tx", 32'(capq[0]), 32'hA5C3);
    rd(8'h1C, d); chk("R3 16-bit rx", d, 32'hBEEF);

    // R6 and R8 full buffers
    sw = 16'h00C3;
    cfg(0, 0, 1, 8, 1);
    wr(8'h0C, 32'h08);
    wr(8'h34, 32'h11); wr(8'h34, 32'h22); wr(8'h34, 32'h33);
    rd(8'h10, d); chk("R6 full no slot", 32'(d[6]), 0);
    wr(8'h0C, 32'h04);
    wait_txc();
    chk("R6 two frames", 32'(cap_n), 2);
    chk("R6 first", 32'(capq[0]), 32'h11);
    chk("R6 second", 32'(capq[1]), 32'h22);
    wr(8'h34, 32'h44);
    wait_txc();
    chk("R6 third pushed later", 32'(capq[2]), 32'h44);
    rd(8'h40, d); chk("R8 overflow flag", 32'(d[5]), 1);
    rd(8'h1C, d); chk("R8 pop full", d, 32'hC3);
    rd(8'h18, d); chk("R8 pop ext", d, 32'hC3);
    rd(8'h10, d); chk("R8 dropped frame", 32'(d[7]), 0);
    wr(8'h48, 32'h20);
    rd(8'h40, d); chk("R11 ovf cleared", 32'(d[5]), 0);

    // R8 receiver off
    wr(8'h0C, 32'h02);
    wr(8'h34, 32'h99);
    wait_txc();
    rd(8'h10, d); chk("R8 rx off discard", 32'(d[7]), 0);
    wr(8'h0C, 32'h01);

    // R10 txc cleared by push
    wr(8'h0C, 32'h08);
    wr(8'h34, 32'h01);
    rd(8'h10, d); chk("R10 txc cleared", 32'(d[5]), 0);
    wr(8'h0C, 32'h04);
    wait_txc();
    rd(8'h1C, d);

    // R11 and R12 interrupts
    wr(8'h4C, 32'h02);
    @(negedge clk);
    chk("R12 tx irq", 32'(tx_irq), 1);
    wr(8'h48, 32'h02);
    rd(8'h40, d); chk("R11 level stays", d, 32'h02);
    wr(8'h4C, 32'h0);
    @(negedge clk);
    chk("R12 tx irq off", 32'(tx_irq), 0);
    wr(8'h44, 32'h04);
    wr(8'h4C, 32'h04);
    @(negedge clk);
    chk("R12 rx irq", 32'(rx_irq), 1);
    wr(8'h48, 32'h04);
    @(negedge clk);
    chk("R12 rx irq cleared", 32'(rx_irq), 0);
    rd(8'h40, d); chk("R11 flags", d, 32'h02);
    wr(8'h4C, 32'h0);

    // random frames: R4, R5, R8
    for (int i = 0; i < 30; i++) begin
      logic cp, ph, mf;
      int nb, dv;
      logic [15:0] tx;
      cp = 1'($urandom); ph = 1'($urandom); mf = 1'($urandom);
      nb = 4 + int'($urandom % 13); dv = int'($urandom % 3);
      tx = 16'($urandom); sw = 16'($urandom);
      cfg(cp, ph, mf, nb, dv);
      wr(8'h34, 32'(tx));
      wait_txc();
      chk("R5 mosi word", 32'(capq[0]), 32'(tx) & msk(nb));
      rd(8'h1C, d); chk("R5 rx word", d, 32'(sw) & msk(nb));
      chk("R4 half period", 32'(iv_bad), 0);
      chk("R4 edge count", 32'(edges), 32'(2*nb));
      chk("R4 idle level", 32'(sclk), 32'(cp));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule